// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a serial stereo PCM stream back into parallel samples. A bit clock, a frame clock and one data line come in from an audio source. All three are brought into a faster system clock domain and sampled there. The bits are assembled into a left word and a right word. Both words are 24 bits wide and left-aligned, and any bits below the received word length read as zero. Once both halves of a stereo frame have been received, a one-cycle pulse announces the new pair.

Five framings are supported, selected by a 3-bit format code. Three are right-justified (16, 20 or 24 bits), one is left-justified 24-bit, and one is I2S. They differ in which frame clock level means left, where the word sits inside each half-frame, and how many bit clocks a frame needs. The format code is read once after reset, so a system with several data lines uses one receiver per line.

Top module: `aud_serial_rx`

## Requirements
- R1: Data is taken MSB first, only at rising edges of `bit_clk`. A change on `ser_data` while `bit_clk` is high has no effect.
- R2: Format 0 is 16-bit right-justified. `frame_clk` high marks the left half. The word occupies the last 16 bit clocks of each half, earlier bits are ignored, and the word appears in bits 23..8 of the output with bits 7..0 zero. It works with 32 or more bit clocks per frame.
- R3: Format 1 is 20-bit right-justified with the same polarity. The word occupies the last 20 bit clocks of each half and appears in bits 23..4 of the output with bits 3..0 zero. It works with 40 or more bit clocks per frame.
- R4: Format 4 is 24-bit right-justified with the same polarity. The word occupies the last 24 bit clocks of each half, and earlier bits are ignored. It works with 48 or more bit clocks per frame.
- R5: Format 2 is 24-bit left-justified with the same polarity. The MSB is on the first bit clock after a `frame_clk` change, and bits after the 24th are ignored. A 16- or 20-bit word sent with zero low bits comes out unchanged.
- R6: Format 3 is I2S. `frame_clk` low marks the left half, and the MSB is on the second bit clock after a `frame_clk` change. With 48 or 64 bit clocks per frame, 24 bits are taken. With 32, 16 bits are taken (the last one on the first bit clock of the next half), placed in bits 23..8 with bits 7..0 zero.
- R7: `valid` is a single-cycle pulse that rises once per frame, after a left half and then a right half have both been received. The partial frame seen just after reset produces no pulse.
- R8: `left_word` and `right_word` change only in the cycle `valid` is high, and hold their values otherwise.
- R9: `fmt_sel` is read once, in the first cycle after reset is released. Later changes have no effect until the next reset.
- R10: Format codes 5, 6 and 7 produce no `valid` pulse, whatever the stream.
- R11: While `rst_n` is low, `valid` is low and both words are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock, asynchronous to clk |
| frame_clk | input | 1 | Left/right frame clock |
| ser_data | input | 1 | Serial audio data |
| fmt_sel | input | 3 | Framing format code (0..4 used) |
| valid | output | 1 | One-cycle pulse when a new stereo pair is ready |
| left_word | output | 24 | Left sample, left-aligned |
| right_word | output | 24 | Right sample, left-aligned |

## Verification
Every kind of internal fault shows up at the next `valid` pulse, roughly one frame after the fault:
- A wrong bit counter or a misplaced I2S delay shifts the word one position, or drops its LSB.
- A wrong polarity decision swaps the left and right words, or shifts the frames by half a frame.
- A broken pairing flag either loses pulses or shows up in the pulse count.

A stuck format register shows up at the first frame in the wrong framing. The zero-padding and hold checks on the outputs report a fault in the same cycle it happens.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   // Output sample width; every framing is aligned to this many bits.
   localparam int SAMPLE_W = 24;

   // Framing codes. Their values are visible at the fmt_sel port.
   localparam logic [2:0] FMT_RJ16 = 3'd0;
   localparam logic [2:0] FMT_RJ20 = 3'd1;
   localparam logic [2:0] FMT_LJ24 = 3'd2;
   localparam logic [2:0] FMT_I2S  = 3'd3;
   localparam logic [2:0] FMT_RJ24 = 3'd4;

   function automatic logic fmt_known(input logic [2:0] f);
      return f <= FMT_RJ24;
   endfunction

   function automatic logic fmt_is_rj(input logic [2:0] f);
      return (f == FMT_RJ16) || (f == FMT_RJ20) || (f == FMT_RJ24);
   endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_clk,
   input  logic frame_clk,
   input  logic ser_data,
   output logic bit_stb,
   output logic lr_s,
   output logic dat_s
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 4) else $error("aud_rx_sync: STAGES out of range");
   end

   logic [2:0] raw;
   logic [2:0] tamed;
   assign raw = {bit_clk, frame_clk, ser_data};

   // All three lines travel through the same number of stages, so they
   // stay aligned to each other in the system domain.
   generate
      if (STAGES == 0) begin : g_direct
         assign tamed = raw;
      end else begin : g_chain
         logic [STAGES-1:0][2:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= raw;
               for (int i = 1; i < STAGES; i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign tamed = chain[STAGES-1];
      end
   endgenerate

   logic bck_prev;

   // Rising-edge detection on the bit clock. The frame clock and data are
   // registered alongside, so they are the values present at that edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bck_prev <= 1'b0;
         bit_stb  <= 1'b0;
         lr_s     <= 1'b0;
         dat_s    <= 1'b0;
      end else begin
         bck_prev <= tamed[2];
         bit_stb  <= tamed[2] & ~bck_prev;
         lr_s     <= tamed[1];
         dat_s    <= tamed[0];
      end
   end

   AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n) bit_stb |=> !bit_stb) else $error("bit strobe lasted two cycles"); // R1

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
   import aud_rx_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [2:0]          fmt,
   input  logic                bit_stb,
   input  logic                lr,
   input  logic                dat,
   output logic                half_done,
   output logic                half_left,
   output logic [SAMPLE_W-1:0] half_word
);

   localparam int               CNT_W    = $clog2(SAMPLE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);
   localparam logic [CNT_W-1:0] TOP_IDX  = CNT_W'(SAMPLE_W - 1);
   localparam logic [1:0]       PRIMED   = 2'd2;

   logic                is_i2s;
   logic                lr_d1;      // frame clock seen at the previous bit
   logic                sel;        // frame level that delimits halves
   logic                sel_prev;
   logic [1:0]          prime;      // bits seen since reset, saturating
   logic                started;    // a half boundary has been seen
   logic                lr_turn;
   logic [SAMPLE_W-1:0] sr;         // continuous shifter, right-justified
   logic [SAMPLE_W-1:0] acc;        // positional fill, left-justified / I2S
   logic [CNT_W-1:0]    cnt;
   logic [SAMPLE_W-1:0] rj_word;
   logic [SAMPLE_W-1:0] done_word;

   assign is_i2s = (fmt == FMT_I2S);
   // I2S is handled as left-justified on a frame clock delayed by one bit.
   assign sel     = is_i2s ? lr_d1 : lr;
   assign lr_turn = (prime == PRIMED) && (sel != sel_prev);

   always_comb begin
      unique case (fmt)
         FMT_RJ16: rj_word = {sr[15:0], 8'd0};
         FMT_RJ20: rj_word = {sr[19:0], 4'd0};
         default:  rj_word = sr;
      endcase
   end

   assign done_word = fmt_is_rj(fmt) ? rj_word : acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_d1     <= 1'b0;
         sel_prev  <= 1'b0;
         prime     <= 2'd0;
         started   <= 1'b0;
         sr        <= '0;
         acc       <= '0;
         cnt       <= '0;
         half_done <= 1'b0;
         half_left <= 1'b0;
         half_word <= '0;
      end else begin
         half_done <= 1'b0;
         if (run && bit_stb) begin
            lr_d1    <= lr;
            sel_prev <= sel;
            if (prime != PRIMED) prime <= prime + 2'd1;
            sr <= {sr[SAMPLE_W-2:0], dat};
            if (lr_turn) begin
               started   <= 1'b1;
               half_done <= started & fmt_known(fmt);
               half_left <= sel_prev ^ is_i2s;
               half_word <= done_word;
               acc       <= {dat, {(SAMPLE_W-1){1'b0}}};
               cnt       <= CNT_W'(1);
            end else if (cnt < CNT_FULL) begin
               acc[TOP_IDX - cnt] <= dat;
               cnt                <= cnt + CNT_W'(1);
            end
         end
      end
   end

   AST_DONE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n) half_done |-> $past(bit_stb)) else $error("half completed without a bit"); // R1
   AST_DONE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) half_done |-> fmt_known(fmt)) else $error("half completed in unused format"); // R10

endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair
   import aud_rx_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                half_done,
   input  logic                half_left,
   input  logic [SAMPLE_W-1:0] half_word,
   output logic                valid,
   output logic [SAMPLE_W-1:0] left_word,
   output logic [SAMPLE_W-1:0] right_word
);

   logic [SAMPLE_W-1:0] left_hold;
   logic                have_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold  <= '0;
         have_left  <= 1'b0;
         valid      <= 1'b0;
         left_word  <= '0;
         right_word <= '0;
      end else begin
         valid <= 1'b0;
         if (half_done) begin
            if (half_left) begin
               left_hold <= half_word;
               have_left <= 1'b1;
            end else if (have_left) begin
               left_word  <= left_hold;
               right_word <= half_word;
               valid      <= 1'b1;
               have_left  <= 1'b0;
            end
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid) else $error("valid wider than one cycle"); // R7
   AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rst_n) !valid |-> $stable(left_word)) else $error("left word moved without valid"); // R8
   AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n) !valid |-> $stable(right_word)) else $error("right word moved without valid"); // R8

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
   import aud_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bit_clk,
   input  logic        frame_clk,
   input  logic        ser_data,
   input  logic [2:0]  fmt_sel,
   output logic        valid,
   output logic [23:0] left_word,
   output logic [23:0] right_word
);

   initial begin
      assert (SAMPLE_W == 24) else $error("aud_serial_rx: port width assumes 24-bit samples");
   end

   logic       cfg_loaded;
   logic [2:0] fmt_q;

   // Format capture: once per reset, in the first cycle after release.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_loaded <= 1'b0;
         fmt_q      <= 3'd0;
      end else if (!cfg_loaded) begin
         cfg_loaded <= 1'b1;
         fmt_q      <= fmt_sel;
      end
   end

   logic                bit_stb;
   logic                lr_s;
   logic                dat_s;
   logic                half_done;
   logic                half_left;
   logic [SAMPLE_W-1:0] half_word;

   aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_clk   (bit_clk),
      .frame_clk (frame_clk),
      .ser_data  (ser_data),
      .bit_stb   (bit_stb),
      .lr_s      (lr_s),
      .dat_s     (dat_s)
   );

   aud_rx_framer u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (cfg_loaded),
      .fmt       (fmt_q),
      .bit_stb   (bit_stb),
      .lr        (lr_s),
      .dat       (dat_s),
      .half_done (half_done),
      .half_left (half_left),
      .half_word (half_word)
   );

   aud_rx_pair u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .half_done  (half_done),
      .half_left  (half_left),
      .half_word  (half_word),
      .valid      (valid),
      .left_word  (left_word),
      .right_word (right_word)
   );

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) cfg_loaded |=> $stable(fmt_q)) else $error("format changed after capture"); // R9
   AST_UNUSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (cfg_loaded && fmt_q > FMT_RJ24) |-> !valid) else $error("valid in unused format"); // R10
   AST_RJ16_PAD: assert property (@(posedge clk) disable iff (!rst_n) (valid && fmt_q == FMT_RJ16) |-> (left_word[7:0] == 8'd0 && right_word[7:0] == 8'd0)) else $error("16-bit pad not zero"); // R2
   AST_RJ20_PAD: assert property (@(posedge clk) disable iff (!rst_n) (valid && fmt_q == FMT_RJ20) |-> (left_word[3:0] == 4'd0 && right_word[3:0] == 4'd0)) else $error("20-bit pad not zero"); // R3

endmodule

// File: tb/aud_serial_rx_test.sv
module aud_serial_rx_test;

   localparam int CLK_P    = 10;
   localparam int HALF_BIT = 4;    // system clocks per bit-clock phase
   localparam int NVEC     = 11;

   // {format, bit clocks per frame, left value, right value}
   localparam logic [57:0] VEC [NVEC] = '{
      {3'd0, 7'd32, 24'h80F1E2, 24'h7F0E1D},
      {3'd0, 7'd64, 24'h123456, 24'hFEDCBA},
      {3'd1, 7'd40, 24'hABCDEF, 24'h13579B},
      {3'd1, 7'd64, 24'h5A5A5A, 24'hC3C3C3},
      {3'd4, 7'd48, 24'h800001, 24'h7FFFFE},
      {3'd4, 7'd64, 24'h0F0F0F, 24'hF00F00},
      {3'd2, 7'd48, 24'hC0FFEE, 24'h31F00D},
      {3'd2, 7'd64, 24'h9ABC00, 24'h123400},
      {3'd3, 7'd32, 24'hA1B2C3, 24'h4D5E6F},
      {3'd3, 7'd48, 24'h876543, 24'h0AB0CD},
      {3'd3, 7'd64, 24'hE1E2E3, 24'h1F2F3F}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_clk = 1'b0;
   logic        frame_clk = 1'b0;
   logic        ser_data = 1'b0;
   logic [2:0]  fmt_sel = 3'd0;
   logic        valid;
   logic [23:0] left_word;
   logic [23:0] right_word;

   always #(CLK_P/2) clk = ~clk;

   aud_serial_rx uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_clk    (bit_clk),
      .frame_clk  (frame_clk),
      .ser_data   (ser_data),
      .fmt_sel    (fmt_sel),
      .valid      (valid),
      .left_word  (left_word),
      .right_word (right_word)
   );

   int          checks = 0;
   int          errors = 0;
   int          ncap = 0;
   int          run_len = 0;
   int          wide_pulses = 0;
   logic [23:0] cap_l [8];
   logic [23:0] cap_r [8];
   logic        pend = 1'b0;   // I2S bit carried into the next half

   // Output monitor, sampled on the falling clock edge.
   always @(negedge clk) begin
      if (valid) begin
         if (ncap < 8) begin
            cap_l[ncap] = left_word;
            cap_r[ncap] = right_word;
         end
         ncap++;
         run_len++;
         if (run_len > 1) wide_pulses++;
      end else begin
         run_len = 0;
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete act=%0d exp=%0d", 0, 1);
      finish_run();
   end

   task automatic chk(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [2:0] m);
      case (m)
         3'd0:    return "R2";
         3'd1:    return "R3";
         3'd2:    return "R5";
         3'd3:    return "R6";
         3'd4:    return "R4";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [23:0] expect_word(input logic [2:0] m, input int bpf, input logic [23:0] w);
      int n;
      n = (m == 3'd0) ? 16 : (m == 3'd1) ? 20 : (m == 3'd3 && bpf == 32) ? 16 : 24;
      return w & (24'hFFFFFF << (24 - n));
   endfunction

   // One bit slot. The data line flips while the bit clock is high: R1.
   task automatic put_slot(input logic lr, input logic d);
      frame_clk = lr;
      ser_data  = d;
      repeat (HALF_BIT) @(posedge clk);
      #1;
      bit_clk = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      ser_data = ~d;
      repeat (HALF_BIT - 2) @(posedge clk);
      #1;
      bit_clk = 1'b0;
   endtask

   task automatic send_frame(input logic [2:0] m, input int bpf, input logic [23:0] l, input logic [23:0] r);
      int          half;
      int          n;
      int          j;
      logic [23:0] w;
      logic        lr;
      logic        b;
      logic        mf;
      half = bpf / 2;
      n = (m == 3'd0) ? 16 : (m == 3'd1) ? 20 : 24;
      for (int h = 0; h < 2; h++) begin
         w  = (h == 0) ? l : r;
         lr = (m == 3'd3) ? (h != 0) : (h == 0);
         for (int k = 0; k < half; k++) begin
            if (m == 3'd0 || m == 3'd1 || m == 3'd4) begin
               j = k - (half - n);
               b = (k >= half - n) ? w[23 - j] : 1'b1;
            end else if (m == 3'd3) begin
               if (k == 0) b = pend;
               else b = (k - 1 < 24) ? w[23 - (k - 1)] : 1'b1;
            end else begin
               b = (k < 24) ? w[23 - k] : 1'b1;
            end
            put_slot(lr, b);
         end
         if (m == 3'd3) begin
            mf = (half - 1 < 24) ? w[23 - (half - 1)] : 1'b1;
            pend = mf;
         end
      end
   endtask

   task automatic do_reset(input logic [2:0] m);
      #1;
      rst_n = 1'b0;
      fmt_sel = m;
      bit_clk = 1'b0;
      pend = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      ncap = 0;
      wide_pulses = 0;
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic stream(input logic [2:0] m, input int bpf, input logic [23:0] l, input logic [23:0] r);
      send_frame(m, bpf, 24'h000000, 24'h000000);   // preamble
      send_frame(m, bpf, l, r);
      send_frame(m, bpf, ~l, ~r);
      send_frame(m, bpf, 24'h000000, 24'h000000);   // closes the last half
      repeat (20) @(posedge clk);
   endtask

   initial begin
      logic [2:0]  m;
      int          bpf;
      logic [23:0] l;
      logic [23:0] r;
      string       rq;

      // R11: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11", "valid in reset", {23'd0, valid}, 24'd0);
      chk("R11", "left in reset", left_word, 24'd0);
      chk("R11", "right in reset", right_word, 24'd0);

      // Vector table: every framing and frame length
      for (int v = 0; v < NVEC; v++) begin
         m   = VEC[v][57:55];
         bpf = int'(VEC[v][54:48]);
         l   = VEC[v][47:24];
         r   = VEC[v][23:0];
         rq  = req_of(m);
         do_reset(m);
         stream(m, bpf, l, r);
         chk("R7", "pulse count", 24'(ncap), 24'd2);
         chk(rq, "frame0 left", cap_l[0], expect_word(m, bpf, l));
         chk(rq, "frame0 right", cap_r[0], expect_word(m, bpf, r));
         chk(rq, "frame1 left", cap_l[1], expect_word(m, bpf, ~l));
         chk(rq, "frame1 right", cap_r[1], expect_word(m, bpf, ~r));
         chk("R7", "wide pulses", 24'(wide_pulses), 24'd0);
      end

      // R8: words hold with the bit clock idle
      repeat (200) @(posedge clk);
      @(negedge clk);
      chk("R8", "left held", left_word, expect_word(3'd3, 64, ~24'hE1E2E3));
      chk("R8", "right held", right_word, expect_word(3'd3, 64, ~24'h1F2F3F));

      // R11: reset clears the words after traffic
      #1;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R11", "left after reset", left_word, 24'd0);
      chk("R11", "right after reset", right_word, 24'd0);

      // R10: unused format codes stay silent
      do_reset(3'd5);
      stream(3'd5, 64, 24'h123456, 24'h654321);
      chk("R10", "pulses in format 5", 24'(ncap), 24'd0);
      chk("R10", "left in format 5", left_word, 24'd0);
      do_reset(3'd7);
      stream(3'd7, 48, 24'hFFFFFF, 24'hAAAAAA);
      chk("R10", "pulses in format 7", 24'(ncap), 24'd0);

      // R9: format change after reset release is ignored
      do_reset(3'd2);
      fmt_sel = 3'd0;
      stream(3'd2, 48, 24'h89ABCD, 24'h0123EF);
      chk("R9", "pulse count", 24'(ncap), 24'd2);
      chk("R9", "left keeps 24-bit framing", cap_l[0], 24'h89ABCD);
      chk("R9", "right keeps 24-bit framing", cap_r[0], 24'h0123EF);

      // R5: 20-bit word carried in left-justified framing
      do_reset(3'd2);
      stream(3'd2, 48, 24'hFEDCB0, 24'h000010);
      chk("R5", "20-bit left", cap_l[0], 24'hFEDCB0);
      chk("R5", "20-bit right", cap_r[0], 24'h000010);

      finish_run();
   end

endmodule